// File: doc/BRIEF.md
# Job Stream Parser and Dispatcher

This block sits between an unframed 32-bit word stream and a bank of compute engines. Jobs arrive back to back, split or merged at any word boundary. Each job is a synchronisation word, an engine identifier, a job tag, a payload whose length depends on the engine, and a closing checksum word. The parser looks for the synchronisation word and ignores everything in front of it. It then compares the identifier against a constant table of engine identifiers, one entry for each attached engine, and pulses that engine's start line. Next it hands the payload words to that engine in order. Last, it checks the closing word so that the sum of the identifier, the tag, the payload and the checksum is zero modulo 2^32.

Both stream interfaces follow one transfer rule: a word is taken only in a cycle whose preceding cycle showed the receiver ready. A small input buffer absorbs the word that a sender may already have committed when ready falls. Result lines coming back from the engines (data, valid, done) are selected by the index of the engine chosen last. The shared result-ready line is fanned out to all engines.

Top module: `jobframe_dispatch`

## Requirements
- R1: After reset all start lines, payload valid lines and status pulses are low, and the input ready line is high.
- R2: In hunting state every word that is not 0xE1E4C312 is discarded, and nothing reaches any engine.
- R3: When the identifier matches table entry i, the parser pulses start line i for exactly one cycle after it takes the job tag word. Start lines are at most one-hot.
- R4: Payload words reach engine i in arrival order, and their count equals entry i of the payload length table. Valid line i is high only in a cycle that follows a cycle with that engine's ready high.
- R5: An input word counts only if input valid is high and input ready was high in the previous cycle. No word is lost or duplicated across idle gaps.
- R6: An identifier missing from the table gives a one-cycle unknown-identifier pulse and no start. The parser then returns to hunting.
- R7: When the modulo-2^32 sum of the identifier, tag, payload and checksum word is zero, the parser gives a one-cycle good-job pulse. Any other sum gives a one-cycle checksum-error pulse. Either way the parser returns to hunting.
- R8: An engine whose payload length is zero receives its start pulse, and the checksum word follows the tag directly.
- R9: Result data, result valid and done follow the engine chosen by the most recent matched identifier. The engines' result-ready line equals the result-ready input.
- R10: The job tag and engine index outputs hold the values captured for the current job while its start pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Incoming stream word |
| in_valid | input | 1 | Incoming word present |
| in_ready | output | 1 | Parser can take a word next cycle |
| eng_start | output | NMOD | One-cycle start pulse per engine |
| eng_src_data | output | 32 | Payload word to engines |
| eng_src_valid | output | NMOD | Payload valid per engine |
| eng_src_ready | input | NMOD | Payload ready per engine |
| eng_dst_data | input | NMOD*32 | Result words from engines, engine i at bits i*32 upward |
| eng_dst_valid | input | NMOD | Result valid per engine |
| eng_dst_ready | output | 1 | Result ready fanned out to all engines |
| eng_done | input | NMOD | Done per engine |
| res_data | output | 32 | Selected engine's result word |
| res_valid | output | 1 | Selected engine's result valid |
| res_ready | input | 1 | Downstream ready for results |
| res_done | output | 1 | Selected engine's done |
| job_tag | output | 32 | Tag of the current job |
| job_eng | output | 3 | Index of the selected engine |
| bad_id | output | 1 | Unknown-identifier pulse |
| bad_sum | output | 1 | Checksum-error pulse |
| job_ok | output | 1 | Good-checksum pulse |

## Verification
The bench builds the block with five engines whose payload lengths are 8, 4, 1, 0 and 3 words and with a three-entry input buffer. These lengths cover the longest payload, the single-word payload and the zero-length path in which the checksum follows the tag at once. The engines' ready lines toggle at random and the input idles at random, so the buffer keeps filling to its limit while the one-cycle ready rule holds on both sides. A mix of good frames, corrupted checksums and unknown identifiers with garbage words in between shows that the parser returns to hunting after each outcome.

// File: rtl/jd_pkg.sv
package jd_pkg;
   typedef enum logic [2:0] {
      ST_HUNT,
      ST_ENG,
      ST_TAG,
      ST_PAY,
      ST_SUM
   } jd_state_e;
endpackage

// File: rtl/jd_skid.sv
module jd_skid #(
   parameter int W     = 32,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_data,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         head_valid
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          rdy_q;
   logic          push, take;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   // room for the word in flight plus one more
   assign in_ready   = (cnt <= CW'(DEPTH - 2));
   assign push       = in_valid & rdy_q;
   assign head_valid = (cnt != '0);
   assign take       = pop & head_valid;
   assign head       = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         cnt   <= '0;
         rdy_q <= 1'b0;
      end else begin
         rdy_q <= in_ready;
         if (push) wp <= bump(wp);
         if (take) rp <= bump(rp);
         cnt <= cnt + CW'(push) - CW'(take);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= in_data;
   end
endmodule

// File: rtl/jd_idmatch.sv
module jd_idmatch #(
   parameter int                      W       = 32,
   parameter int                      NMOD    = 5,
   parameter int                      LEN_W   = 16,
   parameter int                      IW      = 3,
   parameter logic [NMOD*W-1:0]       ENG_IDS = '0,
   parameter logic [NMOD*LEN_W-1:0]   PAY_LEN = '0
) (
   input  logic [W-1:0]     word,
   output logic             hit,
   output logic [IW-1:0]    idx,
   output logic [LEN_W-1:0] len
);
   logic [NMOD-1:0] match;

   for (genvar g = 0; g < NMOD; g++) begin : g_cmp
      assign match[g] = (word == ENG_IDS[g*W +: W]);
   end

   // lowest index wins when entries repeat
   always_comb begin
      hit = |match;
      idx = '0;
      len = '0;
      for (int i = NMOD - 1; i >= 0; i--) begin
         if (match[i]) begin
            idx = IW'(i);
            len = PAY_LEN[i*LEN_W +: LEN_W];
         end
      end
   end
endmodule

// File: rtl/jd_parse.sv
module jd_parse
   import jd_pkg::*;
#(
   parameter int          W     = 32,
   parameter int          LEN_W = 16,
   parameter int          IW    = 3,
   parameter logic [W-1:0] SYNC  = 32'hE1E4C312
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     head,
   input  logic             head_valid,
   output logic             pop,
   input  logic             hit,
   input  logic [IW-1:0]    hit_idx,
   input  logic [LEN_W-1:0] hit_len,
   input  logic             sel_ready,
   output logic             fwd_valid,
   output logic [W-1:0]     fwd_data,
   output logic             start_p,
   output logic [IW-1:0]    sel,
   output logic [W-1:0]     tag,
   output logic             bad_id,
   output logic             bad_sum,
   output logic             job_ok
);
   jd_state_e        st;
   logic [LEN_W-1:0] rem;
   logic [W-1:0]     acc;
   logic             mrdy_q;

   assign fwd_valid = (st == ST_PAY) & head_valid & mrdy_q;
   assign pop       = head_valid & ((st != ST_PAY) | mrdy_q);
   assign fwd_data  = head;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_HUNT;
         rem     <= '0;
         acc     <= '0;
         mrdy_q  <= 1'b0;
         start_p <= 1'b0;
         sel     <= '0;
         tag     <= '0;
         bad_id  <= 1'b0;
         bad_sum <= 1'b0;
         job_ok  <= 1'b0;
      end else begin
         mrdy_q  <= sel_ready;
         start_p <= 1'b0;
         bad_id  <= 1'b0;
         bad_sum <= 1'b0;
         job_ok  <= 1'b0;
         if (pop) begin
            unique case (st)
               ST_HUNT: if (head == SYNC) st <= ST_ENG;
               ST_ENG: begin
                  if (hit) begin
                     sel <= hit_idx;
                     rem <= hit_len;
                     acc <= head;
                     st  <= ST_TAG;
                  end else begin
                     bad_id <= 1'b1;
                     st     <= ST_HUNT;
                  end
               end
               ST_TAG: begin
                  tag     <= head;
                  acc     <= acc + head;
                  start_p <= 1'b1;
                  st      <= (rem == '0) ? ST_SUM : ST_PAY;
               end
               ST_PAY: begin
                  acc <= acc + head;
                  rem <= rem - 1'b1;
                  if (rem == LEN_W'(1)) st <= ST_SUM;
               end
               ST_SUM: begin
                  if ((acc + head) == '0) job_ok  <= 1'b1;
                  else                    bad_sum <= 1'b1;
                  st <= ST_HUNT;
               end
               default: st <= ST_HUNT;
            endcase
         end
      end
   end
endmodule

// File: rtl/jd_route.sv
module jd_route #(
   parameter int W    = 32,
   parameter int NMOD = 5,
   parameter int IW   = 3
) (
   input  logic [IW-1:0]     sel,
   input  logic              start_p,
   input  logic              fwd_valid,
   input  logic [W-1:0]      fwd_data,
   output logic              sel_ready,
   output logic [NMOD-1:0]   eng_start,
   output logic [W-1:0]      eng_src_data,
   output logic [NMOD-1:0]   eng_src_valid,
   input  logic [NMOD-1:0]   eng_src_ready,
   input  logic [NMOD*W-1:0] eng_dst_data,
   input  logic [NMOD-1:0]   eng_dst_valid,
   output logic              eng_dst_ready,
   input  logic [NMOD-1:0]   eng_done,
   output logic [W-1:0]      res_data,
   output logic              res_valid,
   input  logic              res_ready,
   output logic              res_done
);
   for (genvar g = 0; g < NMOD; g++) begin : g_fan
      assign eng_start[g]     = start_p   & (sel == IW'(g));
      assign eng_src_valid[g] = fwd_valid & (sel == IW'(g));
   end

   assign eng_src_data  = fwd_data;
   assign eng_dst_ready = res_ready;

   always_comb begin
      sel_ready = 1'b0;
      res_data  = '0;
      res_valid = 1'b0;
      res_done  = 1'b0;
      for (int i = 0; i < NMOD; i++) begin
         if (sel == IW'(i)) begin
            sel_ready = eng_src_ready[i];
            res_data  = eng_dst_data[i*W +: W];
            res_valid = eng_dst_valid[i];
            res_done  = eng_done[i];
         end
      end
   end
endmodule

// File: rtl/jobframe_dispatch.sv
module jobframe_dispatch #(
   parameter int                    W          = 32,
   parameter int                    NMOD       = 5,
   parameter int                    LEN_W      = 16,
   parameter int                    SKID_DEPTH = 3,
   parameter logic [W-1:0]          SYNC       = 32'hE1E4C312,
   parameter logic [NMOD*W-1:0]     ENG_IDS    = {32'h12345678, 32'h4CD2E19C, 32'h9323EB24,
                                                  32'hF218E0A2, 32'h2CB31E7C},
   parameter logic [NMOD*LEN_W-1:0] PAY_LEN    = {16'd3, 16'd0, 16'd1, 16'd4, 16'd8},
   localparam int                   IW         = (NMOD > 1) ? $clog2(NMOD) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [W-1:0]      in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [NMOD-1:0]   eng_start,
   output logic [W-1:0]      eng_src_data,
   output logic [NMOD-1:0]   eng_src_valid,
   input  logic [NMOD-1:0]   eng_src_ready,
   input  logic [NMOD*W-1:0] eng_dst_data,
   input  logic [NMOD-1:0]   eng_dst_valid,
   output logic              eng_dst_ready,
   input  logic [NMOD-1:0]   eng_done,
   output logic [W-1:0]      res_data,
   output logic              res_valid,
   input  logic              res_ready,
   output logic              res_done,
   output logic [W-1:0]      job_tag,
   output logic [IW-1:0]     job_eng,
   output logic              bad_id,
   output logic              bad_sum,
   output logic              job_ok
);
   if (NMOD < 1) begin : g_bad_nmod
      $error("NMOD must be at least 1");
   end
   if (SKID_DEPTH < 3) begin : g_bad_depth
      $error("SKID_DEPTH must be at least 3 to honour the registered ready rule");
   end
   if (LEN_W < 1 || W < 1) begin : g_bad_width
      $error("W and LEN_W must be positive");
   end

   logic [W-1:0]     head, fwd_data;
   logic             head_valid, pop, fwd_valid, start_p, sel_ready, hit;
   logic [IW-1:0]    hit_idx, sel;
   logic [LEN_W-1:0] hit_len;

   jd_skid #(.W(W), .DEPTH(SKID_DEPTH)) u_skid (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .pop(pop), .head(head), .head_valid(head_valid)
   );

   jd_idmatch #(.W(W), .NMOD(NMOD), .LEN_W(LEN_W), .IW(IW),
                .ENG_IDS(ENG_IDS), .PAY_LEN(PAY_LEN)) u_match (
      .word(head), .hit(hit), .idx(hit_idx), .len(hit_len)
   );

   jd_parse #(.W(W), .LEN_W(LEN_W), .IW(IW), .SYNC(SYNC)) u_parse (
      .clk(clk), .rst_n(rst_n), .head(head), .head_valid(head_valid), .pop(pop),
      .hit(hit), .hit_idx(hit_idx), .hit_len(hit_len), .sel_ready(sel_ready),
      .fwd_valid(fwd_valid), .fwd_data(fwd_data), .start_p(start_p), .sel(sel),
      .tag(job_tag), .bad_id(bad_id), .bad_sum(bad_sum), .job_ok(job_ok)
   );

   jd_route #(.W(W), .NMOD(NMOD), .IW(IW)) u_route (
      .sel(sel), .start_p(start_p), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
      .sel_ready(sel_ready), .eng_start(eng_start), .eng_src_data(eng_src_data),
      .eng_src_valid(eng_src_valid), .eng_src_ready(eng_src_ready),
      .eng_dst_data(eng_dst_data), .eng_dst_valid(eng_dst_valid),
      .eng_dst_ready(eng_dst_ready), .eng_done(eng_done), .res_data(res_data),
      .res_valid(res_valid), .res_ready(res_ready), .res_done(res_done)
   );

   assign job_eng = sel;
endmodule

// File: rtl/jd_checker.sv
module jd_checker #(
   parameter int NMOD = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NMOD-1:0] eng_start,
   input logic [NMOD-1:0] eng_src_valid,
   input logic [NMOD-1:0] eng_src_ready,
   input logic            bad_id,
   input logic            bad_sum,
   input logic            job_ok
);
   // R3
   start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eng_start));

   // R3
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|eng_start) |=> !(|eng_start));

   // R4
   valid_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(eng_src_valid));

   // R4
   ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|eng_src_valid) |-> (($past(eng_src_ready) & eng_src_valid) != '0));

   // R6
   unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_id |-> !(|eng_start) && !bad_sum && !job_ok);

   // R7
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bad_sum && job_ok));

   // R7
   verdict_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_sum || job_ok) |=> !(bad_sum || job_ok));
endmodule

bind jobframe_dispatch jd_checker #(.NMOD(NMOD)) u_chk (
   .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_src_valid(eng_src_valid),
   .eng_src_ready(eng_src_ready), .bad_id(bad_id), .bad_sum(bad_sum), .job_ok(job_ok)
);

// File: tb/jobframe_dispatch_test.sv
module jobframe_dispatch_test;
   localparam int CLK_PERIOD = 10;
   localparam int NM = 5;
   localparam int W  = 32;
   localparam int LW = 16;
   localparam int IW = 3;
   localparam logic [31:0]      SYNC = 32'hE1E4C312;
   localparam logic [NM*W-1:0]  IDS  = {32'h12345678, 32'h4CD2E19C, 32'h9323EB24,
                                         32'hF218E0A2, 32'h2CB31E7C};
   localparam logic [NM*LW-1:0] LENS = {16'd3, 16'd0, 16'd1, 16'd4, 16'd8};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] in_data;
   logic in_valid, in_ready;
   logic [NM-1:0] eng_start, eng_src_valid, eng_src_ready, eng_dst_valid, eng_done;
   logic [W-1:0] eng_src_data, res_data, job_tag;
   logic [NM*W-1:0] eng_dst_data;
   logic eng_dst_ready, res_valid, res_ready, res_done, bad_id, bad_sum, job_ok;
   logic [IW-1:0] job_eng;

   jobframe_dispatch #(.W(W), .NMOD(NM), .LEN_W(LW), .SKID_DEPTH(3), .SYNC(SYNC),
                       .ENG_IDS(IDS), .PAY_LEN(LENS)) uut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .eng_start(eng_start), .eng_src_data(eng_src_data), .eng_src_valid(eng_src_valid),
      .eng_src_ready(eng_src_ready), .eng_dst_data(eng_dst_data), .eng_dst_valid(eng_dst_valid),
      .eng_dst_ready(eng_dst_ready), .eng_done(eng_done), .res_data(res_data),
      .res_valid(res_valid), .res_ready(res_ready), .res_done(res_done), .job_tag(job_tag),
      .job_eng(job_eng), .bad_id(bad_id), .bad_sum(bad_sum), .job_ok(job_ok)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit mon_en = 1'b0;
   logic [31:0] stim_q[$];
   logic [63:0] exp_ev[$], got_ev[$], exp_fw[$], got_fw[$];
   logic [NM-1:0] prev_mr = '0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] eng_id(input int i);
      return IDS[i*W +: W];
   endfunction

   function automatic int eng_len(input int i);
      return int'(LENS[i*LW +: LW]);
   endfunction

   function automatic logic [31:0] plain_word();
      logic [31:0] w;
      do w = $urandom; while (w == SYNC);
      return w;
   endfunction

   function automatic logic [31:0] foreign_id();
      logic [31:0] w;
      bit known;
      do begin
         w = plain_word();
         known = 1'b0;
         for (int i = 0; i < NM; i++) if (w == eng_id(i)) known = 1'b1;
      end while (known);
      return w;
   endfunction

   task automatic add_frame(input int m, input bit good_id, input bit good_sum);
      logic [31:0] id, tg, w, sum;
      int n;
      stim_q.push_back(SYNC);
      id = good_id ? eng_id(m) : foreign_id();
      stim_q.push_back(id);
      sum = id;
      tg = plain_word();
      stim_q.push_back(tg);
      sum = sum + tg;
      if (good_id) exp_ev.push_back({8'd4, 24'(m), tg});
      else         exp_ev.push_back({8'd3, 56'd0});
      n = good_id ? eng_len(m) : $urandom_range(0, 5);
      for (int k = 0; k < n; k++) begin
         w = plain_word();
         stim_q.push_back(w);
         sum = sum + w;
         if (good_id) exp_fw.push_back({32'(m), w});
      end
      w = 32'd0 - sum;
      if (!good_sum) w = w + 32'd1;
      stim_q.push_back(w);
      if (good_id) exp_ev.push_back(good_sum ? {8'd1, 56'd0} : {8'd2, 56'd0});
   endtask

   // R5: a word is offered only when ready was seen high one cycle earlier
   task automatic run_stream(input int idle_pct);
      bit last_rdy = 1'b0;
      while (stim_q.size() != 0) begin
         @(posedge clk);
         #2;
         if (last_rdy && ($urandom_range(0, 99) >= idle_pct)) begin
            in_data  = stim_q.pop_front();
            in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
         last_rdy = in_ready;
      end
      @(posedge clk);
      #2;
      in_valid = 1'b0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #2;
         for (int i = 0; i < NM; i++) eng_src_ready[i] = ($urandom_range(0, 3) != 0);
      end
   end

   always @(negedge clk) begin
      if (mon_en) begin
         if (|eng_start) begin
            int ix = 0;
            for (int i = 0; i < NM; i++) if (eng_start[i]) ix = i;
            got_ev.push_back({8'd4, 24'(ix), job_tag});
            check(job_eng == IW'(ix), "R10 engine index", 64'(job_eng), 64'(ix));
         end
         if (job_ok)  got_ev.push_back({8'd1, 56'd0});
         if (bad_sum) got_ev.push_back({8'd2, 56'd0});
         if (bad_id)  got_ev.push_back({8'd3, 56'd0});
         for (int i = 0; i < NM; i++) begin
            if (eng_src_valid[i]) begin
               check(prev_mr[i], "R4 valid without prior ready", 64'(prev_mr), 64'(eng_src_valid));
               got_fw.push_back({32'(i), eng_src_data});
            end
         end
      end
      prev_mr = eng_src_ready;
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=drained");
      finish_run();
   end

   initial begin
      int dummy, wait_cnt, n;
      dummy = $urandom(32'd20240611);
      in_valid = 1'b0;
      in_data = '0;
      eng_src_ready = '0;
      eng_dst_data = '0;
      eng_dst_valid = '0;
      eng_done = '0;
      res_ready = 1'b0;
      repeat (4) @(posedge clk);
      #2;
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
      check(eng_start == '0 && eng_src_valid == '0, "R1 engine lines",
            64'({eng_start, eng_src_valid}), 64'd0);
      check({bad_id, bad_sum, job_ok} == 3'b000, "R1 status pulses",
            64'({bad_id, bad_sum, job_ok}), 64'd0);
      mon_en = 1'b1;

      // R2 garbage only: nothing may be forwarded or flagged
      repeat (12) stim_q.push_back(plain_word());
      run_stream(30);
      repeat (10) @(posedge clk);
      #2;
      check(got_ev.size() == 0, "R2 events on garbage", 64'(got_ev.size()), 64'd0);
      check(got_fw.size() == 0, "R2 words on garbage", 64'(got_fw.size()), 64'd0);

      add_frame(3, 1'b1, 1'b1);   // R8 zero-length payload
      add_frame(0, 1'b1, 1'b0);   // R7 mismatch on longest payload
      add_frame(4, 1'b0, 1'b1);   // R6 unknown identifier
      add_frame(2, 1'b1, 1'b1);   // single payload word
      for (int f = 0; f < 36; f++) begin
         int kind = $urandom_range(0, 99);
         n = $urandom_range(0, 2);
         for (int g = 0; g < n; g++) stim_q.push_back(plain_word());
         add_frame($urandom_range(0, NM - 1), kind >= 12, kind < 12 || kind >= 28);
      end
      add_frame(2, 1'b1, 1'b1);
      run_stream(25);

      wait_cnt = 0;
      while ((got_ev.size() < exp_ev.size() || got_fw.size() < exp_fw.size()) && wait_cnt < 3000) begin
         @(posedge clk);
         wait_cnt++;
      end
      repeat (10) @(posedge clk);
      #2;

      // R5 no loss or duplication across gaps
      check(got_fw.size() == exp_fw.size(), "R5 payload count", 64'(got_fw.size()), 64'(exp_fw.size()));
      check(got_ev.size() == exp_ev.size(), "R3 event count", 64'(got_ev.size()), 64'(exp_ev.size()));
      n = (got_fw.size() < exp_fw.size()) ? got_fw.size() : exp_fw.size();
      for (int i = 0; i < n; i++)
         check(got_fw[i] == exp_fw[i], "R4 payload word", got_fw[i], exp_fw[i]);
      n = (got_ev.size() < exp_ev.size()) ? got_ev.size() : exp_ev.size();
      for (int i = 0; i < n; i++) begin
         case (exp_ev[i][63:56])
            8'd4:    check(got_ev[i] == exp_ev[i], "R3 start and R10 tag", got_ev[i], exp_ev[i]);
            8'd3:    check(got_ev[i] == exp_ev[i], "R6 unknown id", got_ev[i], exp_ev[i]);
            default: check(got_ev[i] == exp_ev[i], "R7 checksum verdict", got_ev[i], exp_ev[i]);
         endcase
      end

      // R9 result path follows engine 2 (last matched)
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < NM; i++) eng_dst_data[i*W +: W] = $urandom;
         eng_dst_valid = 5'($urandom);
         eng_done = 5'($urandom);
         res_ready = $urandom_range(0, 1) != 0;
         #1;
         check(res_data == eng_dst_data[2*W +: W], "R9 result data", 64'(res_data),
               64'(eng_dst_data[2*W +: W]));
         check({res_valid, res_done} == {eng_dst_valid[2], eng_done[2]}, "R9 valid/done",
               64'({res_valid, res_done}), 64'({eng_dst_valid[2], eng_done[2]}));
         check(eng_dst_ready == res_ready, "R9 ready fan-out", 64'(eng_dst_ready), 64'(res_ready));
      end
      finish_run();
   end
endmodule